// File: doc/BRIEF.md
# Loopback and Test Mode Controller

This block decides where data flows inside a line interface. It sits between the transmit encoder, the receive decoder and the analog line side. It reads three active-low loopback enables (local, remote, digital), two all-ones insertion controls (transmit and receive) and an active-low alarm test input. From these it produces registered multiplexer selects for the datapath blocks, and the final loss-of-signal, loss-of-clock and code-violation alarm values.

The control inputs are static configuration straps. They may arrive from any clock domain, so each one passes through a synchronizer before it is used. The controls do not act as independent switches. Each overlapping pair has a fixed precedence, so every combination of inputs gives exactly one legal set of selects. All selects come from flops, which means a change of mode reaches the data multiplexers as a clean, single-edge change.

The raw alarms come from the receive-side detectors and are synchronous to the block clock. They are registered once on their way out. While alarm test is active, they are overridden with a fixed alarm pattern. Alarm test never touches the transmit select.

Top module: `loop_test_ctl`

## Requirements
- R1: While reset is held, `tx_src_sel`=0, `rx_front_sel`=0, `dec_src_sel`=0, `rx_out_sel`=0, `ja_place`=0, `los_n`=1, `clklos_n`=1 and `lcv`=0.
- R2: Each loopback enable is active when low. With `lloop_n`=0, `rx_front_sel`=1 (the receiver takes the transmitted line signal and the line inputs are ignored); otherwise `rx_front_sel`=0.
- R3: Local loopback outranks remote and digital loopback. While `lloop_n`=0, `tx_src_sel` is never 1 and `dec_src_sel` is 0, whatever `rloop_n` and `dloop_n` are.
- R4: Remote loopback (`rloop_n`=0, local inactive, `tx_ones`=0) gives `tx_src_sel`=1, which sends received data back to the line in place of terminal data. It also keeps `dec_src_sel`=0 and `rx_out_sel`=0, so received data still reaches the receive outputs.
- R5: Digital loopback (`dloop_n`=0, with local and remote inactive and `rx_ones`=0) gives `dec_src_sel`=1, which feeds encoder output to the decoder and ignores the line. Otherwise `dec_src_sel`=0.
- R6: When remote and digital loopback are both requested with local inactive, remote wins: `tx_src_sel`=1 and `dec_src_sel`=0.
- R7: `tx_ones`=1 gives `tx_src_sel`=2 (all-ones to the line), even over remote loopback. The encoding 3 never appears on `tx_src_sel`.
- R8: `rx_ones`=1 gives `rx_out_sel`=1 (all-ones to the receive outputs) and outranks digital loopback, forcing `dec_src_sel`=0.
- R9: With `alarm_test_n`=0, the block drives `los_n`=0, `clklos_n`=0 and `lcv`=1 whatever the raw alarms are, and leaves `tx_src_sel` as the loopback controls set it.
- R10: With alarm test inactive, `los_n`, `clklos_n` and `lcv` equal `los_raw_n`, `clklos_raw_n` and `lcv_raw` as sampled at the previous clock edge.
- R11: A change on any control input appears on the selects exactly SYNC_STAGES+1 clock edges later (3 with defaults), not one edge earlier.
- R12: `ja_place` is 0 when `ja_en`=0, 1 (transmit path) when `ja_en`=1 and `ja_on_tx`=1, and 2 (receive path) when `ja_en`=1 and `ja_on_tx`=0. It never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lloop_n | input | 1 | Local loopback request, active low |
| rloop_n | input | 1 | Remote loopback request, active low |
| dloop_n | input | 1 | Digital loopback request, active low |
| tx_ones | input | 1 | Send all-ones to the line |
| rx_ones | input | 1 | Send all-ones to the receive outputs |
| alarm_test_n | input | 1 | Alarm test, active low |
| ja_en | input | 1 | Jitter attenuator enable |
| ja_on_tx | input | 1 | Jitter attenuator side: 1 transmit, 0 receive |
| los_raw_n | input | 1 | Raw loss of signal from the detector, active low |
| clklos_raw_n | input | 1 | Raw loss of clock, active low |
| lcv_raw | input | 1 | Raw line code violation, active high |
| rx_front_sel | output | 1 | Receiver source: 0 line, 1 transmitted line signal |
| dec_src_sel | output | 1 | Decoder source: 0 recovered data, 1 encoder output |
| tx_src_sel | output | 2 | Line driver source: 0 terminal, 1 received echo, 2 all-ones |
| rx_out_sel | output | 1 | Receive output source: 0 decoder, 1 all-ones |
| ja_place | output | 2 | Attenuator placement: 0 off, 1 transmit, 2 receive |
| los_n | output | 1 | Loss of signal alarm, active low |
| clklos_n | output | 1 | Loss of clock alarm, active low |
| lcv | output | 1 | Code violation alarm, active high |

## Verification
A wrong priority decision shows up at the ports as a select combination that cannot legally occur, such as echo and digital loopback active together, or digital loopback running under receive all-ones. It appears three edges after the control change, and the bench compares every select at that edge for each overlapping pair of controls. A synchronizer with the wrong depth shifts the change by an edge in either direction, so the bench also checks that the selects still hold their old value one edge before they are due. A fault in the alarm override or in its pass-through stage shows on the three alarm outputs one edge after a raw change, or three edges after an alarm test change.

// File: rtl/loop_test_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings and control-vector layout for the loopback and
// test mode controller. Assumes all consumers decode selects with these values.
package loop_test_pkg;

    // Source feeding the line driver
    typedef enum logic [1:0] {
        TXS_TERMINAL = 2'd0,
        TXS_ECHO     = 2'd1,
        TXS_ONES     = 2'd2
    } tx_src_e;

    // Placement of the jitter attenuator
    typedef enum logic [1:0] {
        JA_OFF = 2'd0,
        JA_TX  = 2'd1,
        JA_RX  = 2'd2
    } ja_place_e;

    // Bit positions inside the synchronized control vector
    localparam int CI_LLOOP_N   = 0;
    localparam int CI_RLOOP_N   = 1;
    localparam int CI_DLOOP_N   = 2;
    localparam int CI_TX_ONES   = 3;
    localparam int CI_RX_ONES   = 4;
    localparam int CI_ATEST_N   = 5;
    localparam int CI_JA_EN     = 6;
    localparam int CI_JA_ON_TX  = 7;
    localparam int CTL_W        = 8;

    // Inactive level of every control: active-low bits idle high
    localparam logic [CTL_W-1:0] CTL_IDLE = 8'b0010_0111;

    // Resolved select set handed to the output register
    typedef struct packed {
        logic      rx_front;
        logic      dec_src;
        tx_src_e   tx_src;
        logic      rx_out;
        ja_place_e ja;
    } sel_t;

    localparam sel_t SEL_RESET = '{
        rx_front: 1'b0,
        dec_src:  1'b0,
        tx_src:   TXS_TERMINAL,
        rx_out:   1'b0,
        ja:       JA_OFF
    };

endpackage

// File: rtl/ltc_sync.sv
`timescale 1ns/1ps
// Module: multi-bit, multi-stage synchronizer for static control straps.
// Assumes each bit is independent and changes rarely, so no bus coherency
// is needed. Resets every stage to RST_VAL.
module ltc_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop captures the asynchronous strap
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d;
            end
        end else begin : g_next
            // Later flops resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ltc_resolve.sv
`timescale 1ns/1ps
// Module: combinational priority resolution of loopback and all-ones
// controls into one legal select set. Assumes a synchronized control vector.
// Precedence: local > remote > digital; tx all-ones > remote;
// rx all-ones > digital.
module ltc_resolve
    import loop_test_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output sel_t             sel
);

    logic want_local, want_remote, want_digital;
    logic act_local, act_remote, act_digital;

    // Decode active-low requests
    always_comb begin
        want_local   = !ctl[CI_LLOOP_N];
        want_remote  = !ctl[CI_RLOOP_N];
        want_digital = !ctl[CI_DLOOP_N];
    end

    // Apply pairwise precedence between loopbacks and all-ones
    always_comb begin
        act_local   = want_local;
        act_remote  = want_remote && !want_local;
        act_digital = want_digital && !want_local && !want_remote
                      && !ctl[CI_RX_ONES];
    end

    // Map active modes onto datapath selects
    always_comb begin
        sel.rx_front = act_local;
        sel.dec_src  = act_digital;
        sel.rx_out   = ctl[CI_RX_ONES];
        if (ctl[CI_TX_ONES])  sel.tx_src = TXS_ONES;
        else if (act_remote)  sel.tx_src = TXS_ECHO;
        else                  sel.tx_src = TXS_TERMINAL;
        if (!ctl[CI_JA_EN])        sel.ja = JA_OFF;
        else if (ctl[CI_JA_ON_TX]) sel.ja = JA_TX;
        else                       sel.ja = JA_RX;
    end

endmodule

// File: rtl/ltc_alarm.sv
`timescale 1ns/1ps
// Module: alarm output stage. Registers raw detector alarms and overrides
// them with the test pattern while test_n is low. Assumes the raw alarms
// are synchronous to clk and test_n is already synchronized.
module ltc_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic test_n,
    input  logic los_raw_n,
    input  logic clklos_raw_n,
    input  logic lcv_raw,
    output logic los_n,
    output logic clklos_n,
    output logic lcv
);

    // Register alarms, forcing the test pattern when requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            los_n    <= 1'b1;
            clklos_n <= 1'b1;
            lcv      <= 1'b0;
        end else if (!test_n) begin
            los_n    <= 1'b0;
            clklos_n <= 1'b0;
            lcv      <= 1'b1;
        end else begin
            los_n    <= los_raw_n;
            clklos_n <= clklos_raw_n;
            lcv      <= lcv_raw;
        end
    end

endmodule

// File: rtl/loop_test_ctl.sv
`timescale 1ns/1ps
// Module: loopback and test mode controller top. Synchronizes the control
// straps, resolves priorities, and registers the selects so that a mode
// change reaches the datapath muxes on a single edge. Assumes the datapath
// muxes decode the loop_test_pkg encodings.
module loop_test_ctl
    import loop_test_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lloop_n,
    input  logic       rloop_n,
    input  logic       dloop_n,
    input  logic       tx_ones,
    input  logic       rx_ones,
    input  logic       alarm_test_n,
    input  logic       ja_en,
    input  logic       ja_on_tx,
    input  logic       los_raw_n,
    input  logic       clklos_raw_n,
    input  logic       lcv_raw,
    output logic       rx_front_sel,
    output logic       dec_src_sel,
    output logic [1:0] tx_src_sel,
    output logic       rx_out_sel,
    output logic [1:0] ja_place,
    output logic       los_n,
    output logic       clklos_n,
    output logic       lcv
);

    logic [CTL_W-1:0] ctl_raw, ctl_sync;
    sel_t             sel_next, sel_q;

    // Gather the straps into one vector in package order
    always_comb begin
        ctl_raw              = '0;
        ctl_raw[CI_LLOOP_N]  = lloop_n;
        ctl_raw[CI_RLOOP_N]  = rloop_n;
        ctl_raw[CI_DLOOP_N]  = dloop_n;
        ctl_raw[CI_TX_ONES]  = tx_ones;
        ctl_raw[CI_RX_ONES]  = rx_ones;
        ctl_raw[CI_ATEST_N]  = alarm_test_n;
        ctl_raw[CI_JA_EN]    = ja_en;
        ctl_raw[CI_JA_ON_TX] = ja_on_tx;
    end

    ltc_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_sync)
    );

    ltc_resolve u_resolve (
        .ctl (ctl_sync),
        .sel (sel_next)
    );

    // Register the selects so the datapath sees one clean change
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_RESET;
        else        sel_q <= sel_next;
    end

    ltc_alarm u_alarm (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_n       (ctl_sync[CI_ATEST_N]),
        .los_raw_n    (los_raw_n),
        .clklos_raw_n (clklos_raw_n),
        .lcv_raw      (lcv_raw),
        .los_n        (los_n),
        .clklos_n     (clklos_n),
        .lcv          (lcv)
    );

    // Drive the select ports from the register
    always_comb begin
        rx_front_sel = sel_q.rx_front;
        dec_src_sel  = sel_q.dec_src;
        tx_src_sel   = sel_q.tx_src;
        rx_out_sel   = sel_q.rx_out;
        ja_place     = sel_q.ja;
    end

endmodule

// File: rtl/loop_test_ctl_chk.sv
`timescale 1ns/1ps
// Module: property checker for loop_test_ctl, attached by bind. Checks
// cross-select legality and the alarm pass-through at the ports.
module loop_test_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       los_raw_n,
    input logic       clklos_raw_n,
    input logic       lcv_raw,
    input logic       rx_front_sel,
    input logic       dec_src_sel,
    input logic [1:0] tx_src_sel,
    input logic       rx_out_sel,
    input logic [1:0] ja_place,
    input logic       los_n,
    input logic       clklos_n,
    input logic       lcv
);

    logic armed;

    // Mark the cycles in which a previous raw sample exists after reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_local_blocks_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_front_sel |-> (tx_src_sel != 2'd1 && !dec_src_sel));

    assert_digital_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_src_sel |-> (tx_src_sel != 2'd1 && !rx_front_sel && !rx_out_sel));

    assert_rx_ones_over_digital_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_sel |-> !dec_src_sel);

    assert_tx_src_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_src_sel != 2'd3);

    assert_ja_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ja_place != 2'd3);

    assert_alarm_test_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !los_n |-> (lcv || !$past(los_raw_n)));

    assert_alarm_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !lcv) |-> (los_n == $past(los_raw_n) && clklos_n == $past(clklos_raw_n)
                             && !$past(lcv_raw)));

endmodule

bind loop_test_ctl loop_test_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .los_raw_n    (los_raw_n),
    .clklos_raw_n (clklos_raw_n),
    .lcv_raw      (lcv_raw),
    .rx_front_sel (rx_front_sel),
    .dec_src_sel  (dec_src_sel),
    .tx_src_sel   (tx_src_sel),
    .rx_out_sel   (rx_out_sel),
    .ja_place     (ja_place),
    .los_n        (los_n),
    .clklos_n     (clklos_n),
    .lcv          (lcv)
);

// File: tb/loop_test_ctl_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver task applies a control set, computes the
// expected ports from the requirements and queues them with a due cycle;
// the monitor pops and compares at the negedge after the due edge.
module loop_test_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n;
    logic lloop_n, rloop_n, dloop_n, tx_ones, rx_ones, alarm_test_n, ja_en, ja_on_tx;
    logic los_raw_n, clklos_raw_n, lcv_raw;
    logic rx_front_sel, dec_src_sel, rx_out_sel, los_n, clklos_n, lcv;
    logic [1:0] tx_src_sel, ja_place;

    int errors = 0;
    int checks = 0;
    int cycle  = 0;
    bit done   = 1'b0;

    typedef struct {
        int         due;
        logic [6:0] sel;   // {rx_front, dec, tx_src[1:0], rx_out, ja[1:0]}
        logic [2:0] alm;   // {los_n, clklos_n, lcv}
        bit         sel_only;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [6:0] prev_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_test_ctl u_loop_test_ctl (
        .clk(clk), .rst_n(rst_n),
        .lloop_n(lloop_n), .rloop_n(rloop_n), .dloop_n(dloop_n),
        .tx_ones(tx_ones), .rx_ones(rx_ones), .alarm_test_n(alarm_test_n),
        .ja_en(ja_en), .ja_on_tx(ja_on_tx),
        .los_raw_n(los_raw_n), .clklos_raw_n(clklos_raw_n), .lcv_raw(lcv_raw),
        .rx_front_sel(rx_front_sel), .dec_src_sel(dec_src_sel), .tx_src_sel(tx_src_sel),
        .rx_out_sel(rx_out_sel), .ja_place(ja_place),
        .los_n(los_n), .clklos_n(clklos_n), .lcv(lcv)
    );

    // Count rising edges
    always @(posedge clk) cycle <= cycle + 1;

    // Expected selects from the requirements
    function automatic logic [6:0] exp_sel();
        logic loc, rem, dig;
        logic [1:0] txs, ja;
        loc = !lloop_n;
        rem = !rloop_n && !loc;
        dig = !dloop_n && !loc && rloop_n && !rx_ones;
        txs = tx_ones ? 2'd2 : (rem ? 2'd1 : 2'd0);
        ja  = !ja_en ? 2'd0 : (ja_on_tx ? 2'd1 : 2'd2);
        return {loc, dig, txs, rx_ones, ja};
    endfunction

    function automatic logic [2:0] exp_alm();
        if (!alarm_test_n) return 3'b001;
        return {los_raw_n, clklos_raw_n, lcv_raw};
    endfunction

    // Driver: apply a control set, queue the old and new expectations
    task automatic apply(input logic [7:0] c, input logic [2:0] raw, input string tag);
        item_t it;
        @(negedge clk);
        {ja_on_tx, ja_en, alarm_test_n, rx_ones, tx_ones, dloop_n, rloop_n, lloop_n} = c;
        {los_raw_n, clklos_raw_n, lcv_raw} = raw;
        it.due = cycle + LAT - 1; it.sel = prev_sel; it.alm = '0;
        it.sel_only = 1'b1; it.tag = "R11";
        sb_q.push_back(it);
        it.due = cycle + LAT; it.sel = exp_sel(); it.alm = exp_alm();
        it.sel_only = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        prev_sel = it.sel;
        repeat (LAT + 1) @(negedge clk);
    endtask

    // Monitor: compare the due items away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].due == cycle) begin
                item_t it;
                logic [6:0] a_sel;
                logic [2:0] a_alm;
                it    = sb_q.pop_front();
                a_sel = {rx_front_sel, dec_src_sel, tx_src_sel, rx_out_sel, ja_place};
                a_alm = {los_n, clklos_n, lcv};
                checks++;
                if (a_sel !== it.sel || (!it.sel_only && a_alm !== it.alm)) begin
                    errors++;
                    $display("FAIL %s: sel=%b alm=%b expected sel=%b alm=%b",
                             it.tag, a_sel, a_alm, it.sel, it.alm);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: expired after %0d cycles", WATCHDOG);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus; control byte = {ja_on_tx,ja_en,atest_n,rx_ones,tx_ones,dloop_n,rloop_n,lloop_n}
    initial begin
        rst_n = 1'b0;
        {ja_on_tx, ja_en, alarm_test_n, rx_ones, tx_ones, dloop_n, rloop_n, lloop_n} = 8'b0010_0111;
        {los_raw_n, clklos_raw_n, lcv_raw} = 3'b001;
        prev_sel = 7'b0;
        repeat (4) @(negedge clk);
        checks++;
        if ({rx_front_sel, dec_src_sel, tx_src_sel, rx_out_sel, ja_place} !== 7'b0 ||
            {los_n, clklos_n, lcv} !== 3'b110) begin
            errors++;
            $display("FAIL R1: sel=%b alm=%b expected sel=0000000 alm=110",
                     {rx_front_sel, dec_src_sel, tx_src_sel, rx_out_sel, ja_place},
                     {los_n, clklos_n, lcv});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        apply(8'b0010_0111, 3'b110, "R10 idle");
        apply(8'b0010_0110, 3'b110, "R2 local");
        apply(8'b0010_0000, 3'b110, "R3 all loops");
        apply(8'b0010_0010, 3'b110, "R3 local+digital");
        apply(8'b0010_0101, 3'b110, "R4 remote");
        apply(8'b0010_0011, 3'b110, "R5 digital");
        apply(8'b0010_0001, 3'b110, "R6 remote+digital");
        apply(8'b0010_1101, 3'b110, "R7 txones over remote");
        apply(8'b0010_1111, 3'b110, "R7 txones alone");
        apply(8'b0011_0011, 3'b110, "R8 rxones over digital");
        apply(8'b0011_0111, 3'b110, "R8 rxones alone");
        apply(8'b0000_0101, 3'b110, "R9 test with remote");
        apply(8'b0000_0111, 3'b001, "R9 test hides raw");
        apply(8'b0010_0111, 3'b001, "R10 raw alarms");
        apply(8'b0010_0111, 3'b011, "R10 clk only");
        apply(8'b1110_0111, 3'b110, "R12 ja tx");
        apply(8'b0110_0111, 3'b110, "R12 ja rx");
        apply(8'b1010_0111, 3'b110, "R12 ja off");
        apply(8'b0011_1110, 3'b110, "R2 local with both ones");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule